// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block owns the instruction address of a small 16-bit processor and decides, once per clock, where the next instruction comes from. In the normal case the address steps forward by one instruction. When the decode stage presents a branch, the block compares a four-bit condition-select mask against the current negative, zero, carry and overflow flags. If any selected flag is set, the block jumps by a signed 11-bit offset measured from the current address.

The flag inputs are expected to come from the most recent instruction that changed them; this block only reads them. A stall input freezes the address. A branch that is presented during a stall is decided on the first cycle without stall, using the flags present on that cycle. A registered taken pulse follows every jump so that the surrounding pipeline can discard instructions it fetched on the wrong path.

Top module: `branch_addr_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `iaddr` to 0 and `br_taken` to 0 after that edge.
- R2: With `rst` and `stall` low and no branch taken, `iaddr` increases by one at each rising edge, and `br_taken` is 0.
- R3: With `rst` and `stall` low, `br_valid` high and at least one selected flag set, `iaddr` becomes the current `iaddr` plus `br_offset` sign-extended from bit 10, and `br_taken` is 1 for the following cycle.
- R4: The mask bits select the flags as follows: bit 3 negative (`flag_n`), bit 2 zero (`flag_z`), bit 1 carry (`flag_c`), bit 0 overflow (`flag_v`); the branch is taken when any selected flag is 1.
- R5: The target addition wraps modulo 2^16, in both directions, and covers offsets from -1024 to +1023.
- R6: A condition mask of all zeros never takes a branch, whatever the flags; the address then steps by one.
- R7: With `stall` high, `iaddr` keeps its value and `br_taken` is 0, even if a branch with a met condition is presented.
- R8: A branch held across a stall is decided on the first cycle with `stall` low, using the flag values of that cycle.
- R9: With `br_valid` low, the flags and mask have no effect; the address steps by one.
- R10: `br_taken` is high for exactly one cycle per taken branch: in the cycle after a taken branch that is followed by a non-branching cycle, it returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the address when high |
| br_valid | input | 1 | A branch instruction is presented this cycle |
| br_offset | input | 11 | Signed instruction offset of the branch |
| cond_mask | input | 4 | Selected flags: [3] N, [2] Z, [1] C, [0] V |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry-out flag |
| flag_v | input | 1 | Overflow flag |
| iaddr | output | 16 | Current instruction address |
| br_taken | output | 1 | One-cycle pulse after a taken branch |

## Verification
The bench builds the unit with its default widths, a 16-bit address and an 11-bit offset, so that the wrap of the target below zero is reached in the first few cycles after reset without walking the address through 65536 steps. With these widths both extremes of the offset, -1024 and +1023, are driven directly, and each of the four mask bits is tried alone against a lone matching flag and against a lone non-matching flag. Stalls are placed on a pending branch while the flags change underneath it, so the decision visibly follows the flags of the releasing cycle.

// File: rtl/branch_addr_unit.sv
module branch_addr_unit #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              br_valid,
  input  logic [OFS_W-1:0]  br_offset,
  input  logic [3:0]        cond_mask,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic [ADDR_W-1:0] iaddr,
  output logic              br_taken
);

  localparam int EXT_W = ADDR_W - OFS_W;

  logic [3:0]        flags;
  logic              cond_hit;
  logic              jump;
  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] next_addr;

  assign flags     = {flag_n, flag_z, flag_c, flag_v};
  assign cond_hit  = |(cond_mask & flags);
  assign jump      = br_valid && cond_hit && !stall;
  assign ofs_ext   = {{EXT_W{br_offset[OFS_W-1]}}, br_offset};
  assign next_addr = jump ? iaddr + ofs_ext : iaddr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      iaddr    <= '0;
      br_taken <= 1'b0;
    end else begin
      br_taken <= jump;
      if (!stall) iaddr <= next_addr;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (iaddr == '0 && !br_taken));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(iaddr) && !br_taken));

  // R3
  branch_target_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_valid && (cond_mask & {flag_n, flag_z, flag_c, flag_v}) != 4'b0)
    |=> (br_taken && iaddr == $past(iaddr) + {{EXT_W{$past(br_offset[OFS_W-1])}}, $past(br_offset)}));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !br_valid) |=> (!br_taken && iaddr == $past(iaddr) + ADDR_W'(1)));

  // R6
  zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_mask == 4'b0) |=> !br_taken);

endmodule

// File: tb/tb_branch_addr_unit.sv
module tb_branch_addr_unit;

  typedef struct {
    logic [15:0] addr;
    logic        taken;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic        br_valid = 1'b0;
  logic [10:0] br_offset = '0;
  logic [3:0]  cond_mask = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic [15:0] iaddr;
  logic        br_taken;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [15:0] m_addr = '0;

  always #4 clk = ~clk;

  branch_addr_unit dut (
    .clk(clk), .rst(rst), .stall(stall), .br_valid(br_valid),
    .br_offset(br_offset), .cond_mask(cond_mask),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .iaddr(iaddr), .br_taken(br_taken)
  );

  task automatic step(input logic r, input logic s, input logic v,
                      input logic [10:0] o, input logic [3:0] m,
                      input logic [3:0] f, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; stall = s; br_valid = v; br_offset = o; cond_mask = m;
    {flag_n, flag_z, flag_c, flag_v} = f;
    e.taken = 1'b0;
    if (r) m_addr = '0;
    else if (!s) begin
      if (v && (m & f) != 4'b0) begin
        m_addr = m_addr + {{5{o[10]}}, o};
        e.taken = 1'b1;
      end else m_addr = m_addr + 16'd1;
    end
    e.addr = m_addr;
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (iaddr !== e.addr || br_taken !== e.taken) begin
          failures++;
          $display("FAIL %s: iaddr=%h taken=%b expected iaddr=%h taken=%b",
                   e.tag, iaddr, br_taken, e.addr, e.taken);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset
    step(1, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 1, 11'd5, 4'hF, 4'hF, "R1");
    // R5 wrap below zero from address 0
    step(0, 0, 1, 11'h7FF, 4'b0001, 4'b0001, "R5");
    // R10 pulse drops
    step(0, 0, 0, 0, 0, 0, "R10");
    // R2 stepping
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R2");
    // R9 br_valid low ignores met condition
    step(0, 0, 0, 11'd100, 4'hF, 4'hF, "R9");
    // R3 forward branch
    step(0, 0, 1, 11'd5, 4'b1000, 4'b1000, "R3");
    step(0, 0, 0, 0, 0, 0, "R10");
    // R4 each mask bit alone, matching and non-matching flag
    for (int b = 0; b < 4; b++) begin
      step(0, 0, 1, 11'd3, 4'(1 << b), 4'(1 << b), "R4");
      step(0, 0, 1, 11'd3, 4'(1 << b), 4'(1 << ((b + 1) % 4)), "R4");
    end
    // R4 any-of with several selected
    step(0, 0, 1, 11'd7, 4'b1111, 4'b0010, "R4");
    // R6 zero mask never
    step(0, 0, 1, 11'd9, 4'b0000, 4'b1111, "R6");
    // R5 extremes of the offset
    step(0, 0, 1, 11'h3FF, 4'b0100, 4'b0100, "R5");
    step(0, 0, 1, 11'h400, 4'b0100, 4'b0100, "R5");
    step(0, 0, 1, 11'h400, 4'b0100, 4'b0100, "R5");
    // R7 stall holds a met branch
    step(0, 1, 1, 11'd20, 4'b0010, 4'b0010, "R7");
    step(0, 1, 1, 11'd20, 4'b0010, 4'b0010, "R7");
    // R8 flags drop during stall: not taken on release
    step(0, 0, 1, 11'd20, 4'b0010, 4'b0000, "R8");
    step(0, 1, 1, 11'd30, 4'b0001, 4'b0000, "R7");
    // R8 flags rise during stall: taken on release
    step(0, 0, 1, 11'd30, 4'b0001, 4'b0001, "R8");
    step(0, 1, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R2");
    // R1 reset mid-run
    step(1, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R2");
    repeat (2) @(posedge clk);
    #3;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule